// File: doc/BRIEF.md
# Result Register Accumulation Filter

This block takes a stream of converter results, each tagged with the index of its destination result register. It writes them into a small bank of result registers. Each register can either hold single samples or sum pairs of consecutive samples, for averaging or anti-aliasing. A one-bit down-counter per register decides whether an arriving sample opens a new group or is added to the stored one. The counter is reloaded from a per-register pair-mode bit only when it is at zero.

A group is complete either on every sample (pair mode off) or on the second sample of a pair (pair mode on). When a group completes, the register's valid flag is set and a one-cycle result event is raised that carries the register index. Software sets the pair-mode bit through a small configuration port. A read port returns a register's content, its valid flag and its pair-mode bit, and a read clears the valid flag.

Top module: `result_accum_filter`

## Requirements
- R1: After synchronous reset, every register content, counter, valid flag and pair-mode bit is 0, and `evt_pulse` is 0.
- R2: With pair mode 0, each sample (`in_valid`=1) is stored zero-extended into register `in_idx`. The valid flag is then 1 after the clock edge that captured the sample.
- R3: With pair mode 1 and the counter at 0, a sample is stored alone (added to zero), no event is raised, and the valid flag is 0 after the edge.
- R4: With the counter at 1, the next sample for that register is added to the stored content. The valid flag becomes 1 and an event is raised.
- R5: In pair mode the register alternates between a fresh sample and a pair sum. A third sample starts a new pair.
- R6: The sum of two full-scale 10-bit samples (1023+1023) is held exactly as 2046 in the 11-bit register.
- R7: A write to `cfg_pair` takes effect only when the counter is next reloaded. A pair that is already open still completes on its second sample.
- R8: A read returns content, valid flag and pair-mode bit combinationally for `rd_idx`. With `rd_en`=1, the valid flag is 0 after that edge.
- R9: If a read and a completing write hit the same register on the same edge, the read returns the old content and the valid flag is 1 after the edge.
- R10: A sample for one register leaves every other register's content and valid flag unchanged.
- R11: `evt_pulse` is high for exactly the one cycle that follows the completing edge, with `evt_idx` equal to the completed register's index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A conversion result is present |
| in_idx | input | IDX_W | Destination register index |
| in_data | input | SAMPLE_W | Conversion result |
| cfg_we | input | 1 | Write the pair-mode bit |
| cfg_idx | input | IDX_W | Register whose pair-mode bit is written |
| cfg_pair | input | 1 | Pair-mode value (1 = sum pairs) |
| rd_en | input | 1 | Read strobe; clears the valid flag |
| rd_idx | input | IDX_W | Register to read |
| rd_data | output | ACC_W | Register content |
| rd_vld | output | 1 | Valid flag of the register |
| rd_pair | output | 1 | Pair-mode bit of the register |
| evt_pulse | output | 1 | Result event pulse |
| evt_idx | output | IDX_W | Index of the completed register |

## Verification
The bench builds the block with its defaults: 10-bit samples, 11-bit registers and four registers. This puts full-scale pair sums within reach, so the headroom bit is exercised. It also lets every register index be driven while the others are watched for disturbance. With four registers, a mode change in the middle of a pair, a read colliding with a completing write, and reads of idle registers can each be set up on a different register without cross-talk.

// File: rtl/raf_pkg.sv
package raf_pkg;
  // State of the per-register group counter
  typedef enum logic {
    GRP_OPEN = 1'b0,   // next sample starts a new group
    GRP_HALF = 1'b1    // next sample closes a pair
  } grp_cnt_t;
endpackage

// File: rtl/raf_slot.sv
module raf_slot
  import raf_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W    = SAMPLE_W + 1,
  parameter int IDX_W    = 2,
  parameter int ID       = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [IDX_W-1:0]    in_idx,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_pair,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [ACC_W-1:0]    data_q,
  output logic                valid_q,
  output logic                pair_q,
  output logic                complete
);

  // Accumulation arithmetic: base is zero on a new group
  function automatic logic [ACC_W-1:0] acc_next(input logic [ACC_W-1:0] base,
                                                input logic [SAMPLE_W-1:0] s);
    return base + ACC_W'(s);
  endfunction

  grp_cnt_t cnt_q;
  logic     hit, start, closes, rd_hit;

  assign hit      = in_valid && (in_idx == IDX_W'(ID));
  assign start    = hit && (cnt_q == GRP_OPEN);
  assign closes   = hit && (cnt_q == GRP_HALF);
  assign complete = closes || (start && !pair_q);
  assign rd_hit   = rd_en && (rd_idx == IDX_W'(ID));

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q <= 1'b0;
    end else if (cfg_we && (cfg_idx == IDX_W'(ID))) begin
      pair_q <= cfg_pair;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= GRP_OPEN;
      data_q <= '0;
    end else if (start) begin
      data_q <= acc_next('0, in_data);
      cnt_q  <= pair_q ? GRP_HALF : GRP_OPEN;
    end else if (closes) begin
      data_q <= acc_next(data_q, in_data);
      cnt_q  <= GRP_OPEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (complete) begin
      valid_q <= 1'b1;
    end else if (hit || rd_hit) begin
      valid_q <= 1'b0;
    end
  end

  assert_start_fresh_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> (data_q == ACC_W'($past(in_data))));

  assert_pair_sum_R4: assert property (@(posedge clk) disable iff (rst)
    closes |=> (data_q == $past(data_q) + ACC_W'($past(in_data))));

  assert_valid_on_close_R9: assert property (@(posedge clk) disable iff (rst)
    complete |=> valid_q);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !complete) |=> !valid_q);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!hit && !rd_hit) |=> ($stable(data_q) && $stable(valid_q)));

endmodule

// File: rtl/raf_event.sv
module raf_event #(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] complete_vec,
  output logic                evt_pulse,
  output logic [IDX_W-1:0]    evt_idx
);

  logic [IDX_W-1:0] enc;

  always_comb begin
    enc = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (complete_vec[i]) enc = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_pulse <= 1'b0;
      evt_idx   <= '0;
    end else begin
      evt_pulse <= |complete_vec;
      evt_idx   <= enc;
    end
  end

  assert_one_close_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(complete_vec));

  assert_event_follows_R11: assert property (@(posedge clk) disable iff (rst)
    (|complete_vec) |=> (evt_pulse && evt_idx == $past(enc)));

  assert_no_spurious_event_R3: assert property (@(posedge clk) disable iff (rst)
    !(|complete_vec) |=> !evt_pulse);

endmodule

// File: rtl/result_accum_filter.sv
module result_accum_filter #(
  parameter int SAMPLE_W = 10,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ACC_W   = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [IDX_W-1:0]    in_idx,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_pair,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [ACC_W-1:0]    rd_data,
  output logic                rd_vld,
  output logic                rd_pair,
  output logic                evt_pulse,
  output logic [IDX_W-1:0]    evt_idx
);

  logic [ACC_W-1:0]    data_all [NUM_REGS];
  logic [NUM_REGS-1:0] valid_all;
  logic [NUM_REGS-1:0] pair_all;
  logic [NUM_REGS-1:0] complete_vec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    raf_slot #(
      .SAMPLE_W(SAMPLE_W),
      .ACC_W   (ACC_W),
      .IDX_W   (IDX_W),
      .ID      (g)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .in_valid(in_valid),
      .in_idx  (in_idx),
      .in_data (in_data),
      .cfg_we  (cfg_we),
      .cfg_idx (cfg_idx),
      .cfg_pair(cfg_pair),
      .rd_en   (rd_en),
      .rd_idx  (rd_idx),
      .data_q  (data_all[g]),
      .valid_q (valid_all[g]),
      .pair_q  (pair_all[g]),
      .complete(complete_vec[g])
    );
  end

  raf_event #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_event (
    .clk         (clk),
    .rst         (rst),
    .complete_vec(complete_vec),
    .evt_pulse   (evt_pulse),
    .evt_idx     (evt_idx)
  );

  always_comb begin
    rd_data = '0;
    rd_vld  = 1'b0;
    rd_pair = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_data = data_all[i];
        rd_vld  = valid_all[i];
        rd_pair = pair_all[i];
      end
    end
  end

endmodule

// File: tb/result_accum_filter_bench.sv
`timescale 1ns/1ps
module result_accum_filter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_idx = '0;
  logic [9:0]  in_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_pair = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic [10:0] rd_data;
  logic        rd_vld, rd_pair, evt_pulse;
  logic [1:0]  evt_idx;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  result_accum_filter u_result_accum_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pair(cfg_pair),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_vld(rd_vld),
    .rd_pair(rd_pair), .evt_pulse(evt_pulse), .evt_idx(evt_idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // look at one register without clearing its flag
  task automatic peek(input int idx, input int e_data, input int e_vld, input string tag);
    rd_en  = 1'b0;
    rd_idx = 2'(idx);
    #1;
    check(rd_data == 11'(e_data), {tag, " data"}, rd_data, e_data);
    check(rd_vld == 1'(e_vld), {tag, " valid"}, rd_vld, e_vld);
  endtask

  // deliver one sample and check the event in the following cycle
  task automatic send(input int idx, input int d, input bit e_evt, input string tag);
    in_valid = 1'b1;
    in_idx   = 2'(idx);
    in_data  = 10'(d);
    step();
    in_valid = 1'b0;
    check(evt_pulse == e_evt, {tag, " event"}, evt_pulse, e_evt);
    if (e_evt) check(evt_idx == 2'(idx), {tag, " event index"}, evt_idx, idx);
  endtask

  task automatic setcfg(input int idx, input bit p);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_pair = p;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      peek(i, 0, 0, "R1 reset");
      check(rd_pair == 1'b0, "R1 reset pair", rd_pair, 0);
    end
    check(evt_pulse == 1'b0, "R1 reset event", evt_pulse, 0);
  endtask

  task automatic t_single();
    send(0, 5, 1'b1, "R2 single");
    peek(0, 5, 1, "R2 single");
    step();
    check(evt_pulse == 1'b0, "R11 pulse one cycle", evt_pulse, 0);
    send(0, 1023, 1'b1, "R2 single full");
    peek(0, 1023, 1, "R2 single full");
  endtask

  task automatic t_pair();
    setcfg(1, 1'b1);
    rd_idx = 2'd1; #1;
    check(rd_pair == 1'b1, "R8 pair bit readback", rd_pair, 1);
    send(1, 1023, 1'b0, "R3 first of pair");
    peek(1, 1023, 0, "R3 first of pair");
    send(1, 1023, 1'b1, "R4 second of pair");
    peek(1, 2046, 1, "R6 full-scale sum");
    send(1, 7, 1'b0, "R5 new pair");
    peek(1, 7, 0, "R5 new pair");
    send(1, 8, 1'b1, "R5 pair close");
    peek(1, 15, 1, "R5 pair close");
  endtask

  task automatic t_reload_change();
    setcfg(2, 1'b1);
    send(2, 100, 1'b0, "R7 open pair");
    setcfg(2, 1'b0);
    send(2, 50, 1'b1, "R7 open pair closes");
    peek(2, 150, 1, "R7 open pair closes");
    send(2, 3, 1'b1, "R7 new mode single");
    peek(2, 3, 1, "R7 new mode single");
  endtask

  task automatic t_read();
    rd_en = 1'b1; rd_idx = 2'd0; #1;
    check(rd_data == 11'd1023, "R8 read data", rd_data, 1023);
    check(rd_vld == 1'b1, "R8 read valid", rd_vld, 1);
    step();
    rd_en = 1'b0;
    peek(0, 1023, 0, "R8 after read");
  endtask

  task automatic t_collide();
    send(3, 9, 1'b1, "R9 setup");
    rd_en = 1'b1; rd_idx = 2'd3;
    in_valid = 1'b1; in_idx = 2'd3; in_data = 10'd11;
    #1;
    check(rd_data == 11'd9, "R9 read old content", rd_data, 9);
    step();
    rd_en = 1'b0; in_valid = 1'b0;
    check(evt_pulse == 1'b1, "R9 event", evt_pulse, 1);
    peek(3, 11, 1, "R9 flag kept");
  endtask

  task automatic t_independent();
    send(1, 20, 1'b0, "R10 other write");
    send(3, 4, 1'b1, "R10 other write");
    peek(0, 1023, 0, "R10 reg0 untouched");
    peek(2, 3, 1, "R10 reg2 untouched");
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    t_reset();
    t_single();
    t_pair();
    t_reload_change();
    t_read();
    t_collide();
    t_independent();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule